// File: doc/BRIEF.md
# Two-Port Arbitrated Crossbar

This block joins two byte-wide client sources to two byte-wide destination lanes. A client asks for a lane with a two-bit code. The upper bit says that the client wants a connection, and the lower bit names the lane. Once a lane is given to a client, the client keeps it like a circuit, with its grant held high, until it pulses its release line. Any lane that no client owns drives zero.

Each destination lane has its own state machine with three states: `LANE_FREE`, `LANE_BY_A` and `LANE_BY_B`. The transitions are:
- `claim_a` (FREE to BY_A)
- `claim_b` (FREE to BY_B, taken only when A does not claim the same lane)
- `drop_a` (BY_A to FREE, on A's release)
- `drop_b` (BY_B to FREE, on B's release)

All other conditions hold the present state. Decisions always use the lane states as they stood before the clock edge. A lane that is freed in a cycle therefore cannot be claimed until the next cycle.

Each client also has a registered status: idle after reset or release, lane 1, lane 2, or no connection after any other cycle in which it held nothing.

Top module: `xbar2_arb`

## Requirements
- R1: A synchronous active-high reset clears both lanes to free. After the reset edge both grants are low, both data outputs read 8'h00, and both statuses read idle (2'b00).
- R2: A request code has bit 1 as "connect" and bit 0 as the target lane (0 = lane 1, 1 = lane 2). Codes 2'b00 and 2'b01 are no request: they produce no grant, and they leave a non-holding client with status 2'b11 (no connection).
- R3: A client whose request is accepted at a clock edge sees its grant high after that edge. Its grant stays high on every later cycle until it releases. While it holds a lane, that lane's output follows the client's data input combinationally.
- R4: A lane that no client holds drives 8'h00.
- R5: A request for a lane held by the other client is ignored: no grant, and the holder keeps the lane.
- R6: When both clients, holding nothing, request different free lanes in the same cycle, both are granted at the same edge.
- R7: When both clients request the same free lane in the same cycle, client A is granted and client B is not.
- R8: A release drops that client's grant and frees its lane at the next edge, and sets its status to idle (2'b00). A request from the same client in that cycle is ignored. A request from the other client for the lane being freed is also ignored in that cycle.
- R9: A client that holds a lane and requests the other lane is ignored, and its existing connection is unchanged.
- R10: The status encoding is 2'b00 idle, 2'b01 holding lane 1, 2'b10 holding lane 2, and 2'b11 no connection. Status is registered and updates at the same edge as the lane states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_a | input | 2 | Client A request code (bit 1 connect, bit 0 lane) |
| req_b | input | 2 | Client B request code |
| rel_a | input | 1 | Client A release |
| rel_b | input | 1 | Client B release |
| din_a | input | DW | Client A data |
| din_b | input | DW | Client B data |
| dout_1 | output | DW | Lane 1 data |
| dout_2 | output | DW | Lane 2 data |
| gnt_a | output | 1 | Client A holds a lane |
| gnt_b | output | 1 | Client B holds a lane |
| stat_a | output | 2 | Client A status |
| stat_b | output | 2 | Client B status |

## Verification
A lane machine stuck in the wrong state, or an owner taken by the wrong client, shows at the ports right after the edge where it goes wrong. It appears as a grant that disagrees with the status, or as a lane output carrying the wrong client's byte or a nonzero byte while it is free. A wrong release or priority decision shows one cycle after the offending request, because every decision is settled in the single register stage. The walked sequence checks grants, statuses and both lane outputs after every edge, so no error can persist unseen for more than one cycle.

// File: rtl/xbar2_pkg.sv
package xbar2_pkg;

    typedef enum logic [1:0] {
        LANE_FREE = 2'b00,
        LANE_BY_A = 2'b01,
        LANE_BY_B = 2'b10
    } lane_st_t;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'b00,
        CS_LANE1 = 2'b01,
        CS_LANE2 = 2'b10,
        CS_NONE  = 2'b11
    } cli_st_t;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/xbar2_lane_fsm.sv
module xbar2_lane_fsm
    import xbar2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic claim_a,
    input  logic claim_b,
    input  logic rel_a,
    input  logic rel_b,
    output logic own_a,
    output logic own_b,
    output logic nxt_own_a,
    output logic nxt_own_b
);

    lane_st_t state_q, state_d;

    // next-state selection; client A outranks client B on a free lane
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_FREE: begin
                if (claim_a)      state_d = LANE_BY_A;
                else if (claim_b) state_d = LANE_BY_B;
            end
            LANE_BY_A: if (rel_a) state_d = LANE_FREE;
            LANE_BY_B: if (rel_b) state_d = LANE_FREE;
            default:   state_d = LANE_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LANE_FREE;
        else     state_q <= state_d;
    end

    always_comb begin
        own_a     = (state_q == LANE_BY_A);
        own_b     = (state_q == LANE_BY_B);
        nxt_own_a = !rst && (state_d == LANE_BY_A);
        nxt_own_b = !rst && (state_d == LANE_BY_B);
    end

endmodule

// File: rtl/xbar2_status.sv
module xbar2_status
    import xbar2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rel,
    input  logic       nxt_l1,
    input  logic       nxt_l2,
    output logic [1:0] stat
);

    cli_st_t st_q, st_d;

    always_comb begin
        if (rel)         st_d = CS_IDLE;
        else if (nxt_l1) st_d = CS_LANE1;
        else if (nxt_l2) st_d = CS_LANE2;
        else             st_d = CS_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CS_IDLE;
        else     st_q <= st_d;
    end

    assign stat = st_q;

endmodule

// File: rtl/xbar2_arb.sv
module xbar2_arb
    import xbar2_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    req_a,
    input  logic [1:0]    req_b,
    input  logic          rel_a,
    input  logic          rel_b,
    input  logic [DW-1:0] din_a,
    input  logic [DW-1:0] din_b,
    output logic [DW-1:0] dout_1,
    output logic [DW-1:0] dout_2,
    output logic          gnt_a,
    output logic          gnt_b,
    output logic [1:0]    stat_a,
    output logic [1:0]    stat_b
);

    logic [NUM_LANES-1:0] own_a, own_b, nxt_a, nxt_b;
    logic [NUM_LANES-1:0] claim_a, claim_b;
    logic [DW-1:0]        lane_dat [NUM_LANES];
    logic                 holds_a, holds_b;

    assign holds_a = |own_a;
    assign holds_b = |own_b;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic LSEL = 1'(g);

        // a claim needs connect bit, matching lane, no release, nothing held
        assign claim_a[g] = req_a[1] && (req_a[0] == LSEL) && !rel_a && !holds_a;
        assign claim_b[g] = req_b[1] && (req_b[0] == LSEL) && !rel_b && !holds_b;

        xbar2_lane_fsm u_fsm (
            .clk       (clk),
            .rst       (rst),
            .claim_a   (claim_a[g]),
            .claim_b   (claim_b[g]),
            .rel_a     (rel_a),
            .rel_b     (rel_b),
            .own_a     (own_a[g]),
            .own_b     (own_b[g]),
            .nxt_own_a (nxt_a[g]),
            .nxt_own_b (nxt_b[g])
        );

        always_comb begin
            if (own_a[g])      lane_dat[g] = din_a;
            else if (own_b[g]) lane_dat[g] = din_b;
            else               lane_dat[g] = '0;
        end
    end

    xbar2_status u_stat_a (
        .clk    (clk),
        .rst    (rst),
        .rel    (rel_a),
        .nxt_l1 (nxt_a[0]),
        .nxt_l2 (nxt_a[1]),
        .stat   (stat_a)
    );

    xbar2_status u_stat_b (
        .clk    (clk),
        .rst    (rst),
        .rel    (rel_b),
        .nxt_l1 (nxt_b[0]),
        .nxt_l2 (nxt_b[1]),
        .stat   (stat_b)
    );

    assign dout_1 = lane_dat[0];
    assign dout_2 = lane_dat[1];
    assign gnt_a  = holds_a;
    assign gnt_b  = holds_b;

endmodule

// File: rtl/xbar2_arb_chk.sv
module xbar2_arb_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    req_a,
    input logic [1:0]    req_b,
    input logic          rel_a,
    input logic          rel_b,
    input logic [DW-1:0] din_a,
    input logic [DW-1:0] din_b,
    input logic [DW-1:0] dout_1,
    input logic [DW-1:0] dout_2,
    input logic          gnt_a,
    input logic          gnt_b,
    input logic [1:0]    stat_a,
    input logic [1:0]    stat_b
);

    // R10: a grant always pairs with a lane status
    p_gnt_stat_r10: assert property (@(posedge clk) disable iff (rst)
        gnt_a |-> (stat_a == 2'b01 || stat_a == 2'b10));

    // R3: lane 1 held by A carries A's data
    p_route_r3: assert property (@(posedge clk) disable iff (rst)
        (gnt_a && stat_a == 2'b01) |-> dout_1 == din_a);

    // R4: nobody on lane 2 means zero
    p_free_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !(gnt_a && stat_a == 2'b10) && !(gnt_b && stat_b == 2'b10) |-> dout_2 == '0);

    // R5 / R9: an A connection survives anything but A's release
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt_a && stat_a == 2'b01 && !rel_a) |=> (gnt_a && stat_a == 2'b01));

    // R8: release drops the grant and idles the status
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        rel_b |=> (!gnt_b && stat_b == 2'b00));

    // R7: same free lane requested by both, A wins
    p_prio_r7: assert property (@(posedge clk) disable iff (rst)
        (!gnt_a && !gnt_b && req_a == 2'b10 && req_b == 2'b10 && !rel_a)
        |=> (gnt_a && !gnt_b));

    // R6: different free lanes, both granted
    p_both_r6: assert property (@(posedge clk) disable iff (rst)
        (!gnt_a && !gnt_b && req_a == 2'b10 && req_b == 2'b11 && !rel_a && !rel_b)
        |=> (gnt_a && gnt_b));

    // R2: no connect bit, no new grant
    p_noreq_r2: assert property (@(posedge clk) disable iff (rst)
        (!gnt_b && !req_b[1]) |=> !gnt_b);

endmodule

bind xbar2_arb xbar2_arb_chk #(.DW(DW)) u_chk (.*);

// File: tb/xbar2_arb_tb.sv
module xbar2_arb_tb;

    localparam int DW = 8;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    req_a, req_b;
    logic          rel_a, rel_b;
    logic [DW-1:0] din_a, din_b;
    logic [DW-1:0] dout_1, dout_2;
    logic          gnt_a, gnt_b;
    logic [1:0]    stat_a, stat_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    xbar2_arb #(.DW(DW)) u_dut (.*);

    // vector: rst, ra[2], rb[2], la, lb, ga, gb, sa[2], sb[2], sel1[2], sel2[2]
    // status 0 idle,1 lane1,2 lane2,3 none; sel 0 zero,1 A,2 B
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // 0  R1
        {1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 2'd0, 2'd0}, // 1  R2
        {1'b0, 2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 2'd1, 2'd2}, // 2  R6
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 2'd1, 2'd2}, // 3  R3
        {1'b0, 2'b10, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // 4  R8
        {1'b0, 2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3, 2'd1, 2'd0}, // 5  R7
        {1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3, 2'd1, 2'd0}, // 6  R5
        {1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3, 2'd1, 2'd0}, // 7  R9
        {1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 2'd1, 2'd2}, // 8
        {1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 2'd0, 2'd2}, // 9  R8
        {1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 2'd1, 2'd2}, // 10
        {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 2'd1, 2'd0}, // 11 R8
        {1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3, 2'd1, 2'd0}, // 12 R5
        {1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 2'd0, 2'd0}, // 13 R8
        {1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd1, 2'd2, 2'd0}, // 14
        {1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd1, 2'd2, 2'd0}, // 15 R5
        {1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1}, // 16 R10
        {1'b1, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}  // 17 R1
    };

    function automatic logic [DW-1:0] pick(input logic [1:0] sel);
        return (sel == 2'd1) ? din_a : (sel == 2'd2) ? din_b : '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] ra, input logic [1:0] rb,
                        input logic la, input logic lb);
        @(negedge clk);
        rst = r; req_a = ra; req_b = rb; rel_a = la; rel_b = lb;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; req_a = '0; req_b = '0; rel_a = 1'b0; rel_b = 1'b0;
        din_a = 8'hAE; din_b = 8'hFC;
        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            step(v[16], v[15:14], v[13:12], v[11], v[10]);
            chk($sformatf("vec%0d R3 gnt_a", i), 32'(gnt_a), 32'(v[9]));
            chk($sformatf("vec%0d R3 gnt_b", i), 32'(gnt_b), 32'(v[8]));
            chk($sformatf("vec%0d R10 stat_a", i), 32'(stat_a), 32'(v[7:6]));
            chk($sformatf("vec%0d R10 stat_b", i), 32'(stat_b), 32'(v[5:4]));
            chk($sformatf("vec%0d R4 dout_1", i), 32'(dout_1), 32'(pick(v[3:2])));
            chk($sformatf("vec%0d R4 dout_2", i), 32'(dout_2), 32'(pick(v[1:0])));
        end
        // R3: routed data follows input; R4: idle lane stays zero
        step(1'b0, 2'b11, 2'b00, 1'b0, 1'b0);
        chk("R3 granted lane2", 32'(gnt_a), 32'd1);
        din_a = 8'h5A; din_b = 8'h33;
        #1;
        chk("R3 dout_2 follows din_a", 32'(dout_2), 32'h5A);
        chk("R4 dout_1 free zero", 32'(dout_1), 32'h00);
        // R1: reset while connected clears everything
        step(1'b1, 2'b00, 2'b00, 1'b0, 1'b0);
        chk("R1 gnt_a after reset", 32'(gnt_a), 32'd0);
        chk("R1 dout_2 after reset", 32'(dout_2), 32'h00);
        chk("R1 stat_a after reset", 32'(stat_a), 32'd0);
        // R2: code 01 gives no grant and none status
        step(1'b0, 2'b01, 2'b00, 1'b0, 1'b0);
        chk("R2 code01 no grant", 32'(gnt_a), 32'd0);
        chk("R2 code01 status none", 32'(stat_a), 32'd3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule